// File: doc/BRIEF.md
# Parallel NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel NOR flash. It programs a run of consecutive bytes or erases one sector. It generates the unlock and command write cycles itself. It then watches the flash's status byte until the embedded operation finishes, and reports either success or failure. Each bus access takes one clock cycle. A read issued with `fl_re` in one cycle returns its byte on `fl_rdata` in the next cycle.

The user pulses `start` with an operation, a start address, a byte count and a completion-check method. The byte values to program arrive on a valid/ready stream with these back-pressure rules:
- `in_ready` is high only while the sequencer waits for the next byte.
- A byte is taken in any cycle in which `in_valid` and `in_ready` are both high.
- The source may hold `in_valid` low for as long as it likes, and the flash bus stays idle while it does.

A completed operation is signalled by a one-cycle `done` pulse, with `err` showing the outcome. When an operation fails, the sequencer first writes the read-reset command so that the flash returns to array reads, and only then finishes.

Top module: `flash_prog_ctrl`

## Requirements
- R1: Every byte program issues exactly four writes in this order: AAh at 555h, 55h at 2AAh, A0h at 555h, and then the data byte at its target address.
- R2: A sector erase issues exactly six writes in this order: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, and then 30h at the sector's base address. The base address is `start_addr` with its low `SECT_SHIFT` bits cleared.
- R3: In data-poll mode (`poll_toggle`=0), the sequencer reads the target address and treats the operation as finished when bit 7 of the read equals bit 7 of the programmed byte. For an erase, the expected value of bit 7 is 1.
- R4: In data-poll mode, a read whose bit 7 mismatches while bit 5 (the timeout flag) is 1 causes exactly one further read. A match on that read is success and a mismatch is failure. A mismatch while bit 5 is 0 simply leads to another read.
- R5: In toggle mode (`poll_toggle`=1), the sequencer reads the status in pairs. If bit 6 is equal in both reads of a pair, the operation is finished. If bit 6 differs and bit 5 of the second read is 0, another pair is read.
- R6: In toggle mode, a pair whose bit 6 differs while bit 5 of the second read is 1 causes exactly one more pair of reads. If bit 6 still differs in that pair, the operation has failed.
- R7: A program operation of N bytes writes `start_addr`, `start_addr`+1, and so on up to `start_addr`+N-1. It takes one stream byte per address, in stream order. N=0 finishes at once with no bus access and no stream transfer.
- R8: `in_ready` is high only while a byte is awaited, and no flash read or write happens during that wait.
- R9: On failure, the sequencer writes F0h once, then raises `done` with `err`=1, and requests no further stream bytes.
- R10: `done` is a single-cycle pulse, given once per operation. `err` holds its value until the next accepted `start`. A `start` pulse while `busy` is high is ignored.
- R11: The operation type, address, count and polling method are sampled only at the accepted `start`.
- R12: `fl_we` and `fl_re` are never high together, and both stay low while the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| erase_op | input | 1 | 1 = sector erase, 0 = program a byte range |
| poll_toggle | input | 1 | 1 = toggle-bit check, 0 = data-poll check |
| start_addr | input | AW | First byte address, or any address inside the sector to erase |
| byte_count | input | CW | Number of bytes to program |
| in_valid | input | 1 | Stream byte present |
| in_data | input | 8 | Stream byte to program |
| in_ready | output | 1 | Sequencer accepts a stream byte this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Outcome of the last operation (1 = failed) |
| fl_addr | output | AW | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | Flash write strobe, one cycle per write |
| fl_re | output | 1 | Flash read strobe; data returns the next cycle |
| fl_rdata | input | 8 | Flash read data |

## Verification
The bench targets the moment when the timeout flag rises at the same instant that the operation completes. A sequencer that failed on the first timeout read, without the extra re-read in data-poll mode or the extra pair in toggle mode, would report a false failure in that case. The bench also forces a real timeout, and counts the reads and writes exactly. A design that made too many or too few reads, skipped the F0h write, or kept requesting bytes after the failure would be exposed by those counts. A sweep over count, busy length and stream stalls checks the unlock order, address advance and stream handshake. Separate runs cover:
- an erase given an address that is not sector-aligned, which must still be issued at the aligned base address;
- a count of zero;
- a second `start` pulse in mid-run, together with a change of polling method in mid-run, neither of which may disturb the run.

// File: rtl/flash_ctrl_pkg.sv
package flash_ctrl_pkg;

  typedef enum logic [1:0] {
    SEQ_PROG  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_ABORT = 2'd2
  } seq_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_CMD   = 3'd2,
    ST_POLL  = 3'd3,
    ST_FIN   = 3'd4
  } ctrl_state_e;

  typedef enum logic [1:0] {
    PL_IDLE   = 2'd0,
    PL_ISSUE  = 2'd1,
    PL_SAMPLE = 2'd2
  } poll_state_e;

  localparam logic [7:0]  CMD_UNLOCK1      = 8'hAA;
  localparam logic [7:0]  CMD_UNLOCK2      = 8'h55;
  localparam logic [7:0]  CMD_PROGRAM      = 8'hA0;
  localparam logic [7:0]  CMD_ERASE_SETUP  = 8'h80;
  localparam logic [7:0]  CMD_SECTOR_ERASE = 8'h30;
  localparam logic [7:0]  CMD_READ_RESET   = 8'hF0;
  localparam logic [10:0] UNLOCK_ADDR_A    = 11'h555;
  localparam logic [10:0] UNLOCK_ADDR_B    = 11'h2AA;

  localparam int STAT_DONE_BIT   = 7;
  localparam int STAT_TOGGLE_BIT = 6;
  localparam int STAT_TMO_BIT    = 5;

endpackage

// File: rtl/fpc_cmd_table.sv
module fpc_cmd_table
  import flash_ctrl_pkg::*;
#(
  parameter int AW = 19
) (
  input  seq_kind_e       kind,
  input  logic [2:0]      step,
  input  logic [AW-1:0]   target,
  input  logic [7:0]      payload,
  output logic [AW-1:0]   bus_addr,
  output logic [7:0]      bus_data,
  output logic            final_step
);

  localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);

  // Per-kind command programs; step indexes the current write cycle.
  always_comb begin
    bus_addr   = target;
    bus_data   = CMD_READ_RESET;
    final_step = 1'b0;
    if (kind == SEQ_ABORT) begin
      bus_addr   = target;
      bus_data   = CMD_READ_RESET;
      final_step = 1'b1;
    end else begin
      case (step)
        3'd0: begin
          bus_addr = ADDR_A;
          bus_data = CMD_UNLOCK1;
        end
        3'd1: begin
          bus_addr = ADDR_B;
          bus_data = CMD_UNLOCK2;
        end
        3'd2: begin
          bus_addr = ADDR_A;
          bus_data = (kind == SEQ_PROG) ? CMD_PROGRAM : CMD_ERASE_SETUP;
        end
        3'd3: begin
          if (kind == SEQ_PROG) begin
            bus_addr   = target;
            bus_data   = payload;
            final_step = 1'b1;
          end else begin
            bus_addr = ADDR_A;
            bus_data = CMD_UNLOCK1;
          end
        end
        3'd4: begin
          bus_addr = ADDR_B;
          bus_data = CMD_UNLOCK2;
        end
        3'd5: begin
          bus_addr   = target;
          bus_data   = CMD_SECTOR_ERASE;
          final_step = 1'b1;
        end
        default: begin
          bus_addr   = target;
          bus_data   = CMD_READ_RESET;
          final_step = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/fpc_poll_engine.sv
module fpc_poll_engine
  import flash_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       toggle_mode,
  input  logic       exp_q7,
  input  logic [7:0] rd_byte,
  output logic       rd_en,
  output logic       ok,
  output logic       fail
);

  poll_state_e st;
  logic        prev_q6;
  logic        have_first;
  logic        last_chance;

  logic q7_match, q6_same, tmo;

  always_comb begin
    q7_match = (rd_byte[STAT_DONE_BIT] == exp_q7);
    q6_same  = (rd_byte[STAT_TOGGLE_BIT] == prev_q6);
    tmo      = rd_byte[STAT_TMO_BIT];
    rd_en    = (st == PL_ISSUE);
    ok       = 1'b0;
    fail     = 1'b0;
    if (st == PL_SAMPLE) begin
      if (toggle_mode) begin
        ok   = have_first && q6_same;
        fail = have_first && !q6_same && last_chance;
      end else begin
        ok   = q7_match;
        fail = !q7_match && last_chance;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= PL_IDLE;
      prev_q6     <= 1'b0;
      have_first  <= 1'b0;
      last_chance <= 1'b0;
    end else begin
      case (st)
        PL_IDLE: begin
          if (start) begin
            st          <= PL_ISSUE;
            have_first  <= 1'b0;
            last_chance <= 1'b0;
          end
        end
        PL_ISSUE: st <= PL_SAMPLE;
        PL_SAMPLE: begin
          if (ok || fail) begin
            st <= PL_IDLE;
          end else begin
            st <= PL_ISSUE;
            if (toggle_mode) begin
              if (!have_first) begin
                have_first <= 1'b1;
                prev_q6    <= rd_byte[STAT_TOGGLE_BIT];
              end else begin
                have_first <= 1'b0;
                if (tmo) last_chance <= 1'b1;
              end
            end else if (tmo) begin
              last_chance <= 1'b1;
            end
          end
        end
        default: st <= PL_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import flash_ctrl_pkg::*;
#(
  parameter int AW         = 19,
  parameter int CW         = 16,
  parameter int SECT_SHIFT = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          erase_op,
  input  logic          poll_toggle,
  input  logic [AW-1:0] start_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] fl_addr,
  output logic [7:0]    fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [7:0]    fl_rdata
);

  localparam logic [AW-1:0] SECT_MASK = {AW{1'b1}} << SECT_SHIFT;

  ctrl_state_e   state;
  seq_kind_e     kind;
  logic [2:0]    step;
  logic [AW-1:0] target;
  logic [7:0]    payload;
  logic [CW-1:0] remaining;
  logic          toggle_r;
  logic          err_r;

  logic [AW-1:0] tbl_addr;
  logic [7:0]    tbl_data;
  logic          tbl_final;
  logic          poll_start, poll_rd, poll_ok, poll_fail, exp_q7;

  fpc_cmd_table #(.AW(AW)) u_table (
    .kind       (kind),
    .step       (step),
    .target     (target),
    .payload    (payload),
    .bus_addr   (tbl_addr),
    .bus_data   (tbl_data),
    .final_step (tbl_final)
  );

  assign poll_start = (state == ST_CMD) && tbl_final && (kind != SEQ_ABORT);
  assign exp_q7     = (kind == SEQ_ERASE) ? 1'b1 : payload[7];

  fpc_poll_engine u_poll (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (poll_start),
    .toggle_mode (toggle_r),
    .exp_q7      (exp_q7),
    .rd_byte     (fl_rdata),
    .rd_en       (poll_rd),
    .ok          (poll_ok),
    .fail        (poll_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      kind      <= SEQ_PROG;
      step      <= 3'd0;
      target    <= '0;
      payload   <= 8'h00;
      remaining <= '0;
      toggle_r  <= 1'b0;
      err_r     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            toggle_r <= poll_toggle;
            err_r    <= 1'b0;
            step     <= 3'd0;
            if (erase_op) begin
              kind   <= SEQ_ERASE;
              target <= start_addr & SECT_MASK;
              state  <= ST_CMD;
            end else begin
              kind      <= SEQ_PROG;
              target    <= start_addr;
              remaining <= byte_count;
              state     <= (byte_count == '0) ? ST_FIN : ST_FETCH;
            end
          end
        end
        ST_FETCH: begin
          if (in_valid) begin
            payload <= in_data;
            step    <= 3'd0;
            state   <= ST_CMD;
          end
        end
        ST_CMD: begin
          step <= step + 3'd1;
          if (tbl_final) begin
            if (kind == SEQ_ABORT) begin
              err_r <= 1'b1;
              state <= ST_FIN;
            end else begin
              state <= ST_POLL;
            end
          end
        end
        ST_POLL: begin
          if (poll_fail) begin
            kind  <= SEQ_ABORT;
            step  <= 3'd0;
            state <= ST_CMD;
          end else if (poll_ok) begin
            if (kind == SEQ_ERASE || remaining == CW'(1)) begin
              state <= ST_FIN;
            end else begin
              remaining <= remaining - CW'(1);
              target    <= target + AW'(1);
              state     <= ST_FETCH;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy     = (state != ST_IDLE);
    done     = (state == ST_FIN);
    err      = err_r;
    in_ready = (state == ST_FETCH);
    fl_we    = (state == ST_CMD);
    fl_re    = poll_rd;
    fl_addr  = (state == ST_CMD) ? tbl_addr : target;
    fl_wdata = (state == ST_CMD) ? tbl_data : 8'h00;
  end

endmodule

// File: rtl/flash_prog_ctrl_chk.sv
module flash_prog_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       in_ready,
  input logic       fl_we,
  input logic       fl_re,
  input logic [7:0] fl_wdata
);

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_we && !fl_re));

  // R8
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && !fl_we && !fl_re));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(err));

  // R9
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  // R9
  abort_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> $past(fl_we && fl_wdata == 8'hF0));

endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .err      (err),
  .in_ready (in_ready),
  .fl_we    (fl_we),
  .fl_re    (fl_re),
  .fl_wdata (fl_wdata)
);

// File: tb/flash_model.sv
module flash_model #(
  parameter int AW         = 12,
  parameter int SECT_SHIFT = 10
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          we,
  input  logic          re,
  output logic [7:0]    rdata
);

  logic [7:0] mem [0:(1<<AW)-1];

  int busy_reads = 0;
  int q5_at      = 1 << 30;
  int rd_cnt     = 0;
  int wr_cnt     = 0;
  int rst_cnt    = 0;
  int viol       = 0;
  int last_erase = -1;

  int   phase   = 0;
  bit   active  = 0;
  bit   is_erase = 0;
  int   nrd     = 0;
  logic [7:0] pend = 8'h00;

  initial rdata = 8'h00;

  always @(posedge clk) begin
    if (we) begin
      wr_cnt++;
      if (active) begin
        if (wdata == 8'hF0) begin
          active = 0;
          rst_cnt++;
          phase = 0;
        end else viol++;
      end else begin
        case (phase)
          0: if (addr == AW'(12'h555) && wdata == 8'hAA) phase = 1;
             else if (wdata == 8'hF0) rst_cnt++;
             else viol++;
          1: if (addr == AW'(12'h2AA) && wdata == 8'h55) phase = 2;
             else begin viol++; phase = 0; end
          2: if (addr == AW'(12'h555) && wdata == 8'hA0) phase = 3;
             else if (addr == AW'(12'h555) && wdata == 8'h80) phase = 4;
             else begin viol++; phase = 0; end
          3: begin
            mem[addr] = mem[addr] & wdata;
            pend = wdata; is_erase = 0; active = 1; nrd = 0; phase = 0;
          end
          4: if (addr == AW'(12'h555) && wdata == 8'hAA) phase = 5;
             else begin viol++; phase = 0; end
          5: if (addr == AW'(12'h2AA) && wdata == 8'h55) phase = 6;
             else begin viol++; phase = 0; end
          6: begin
            if (wdata == 8'h30) begin
              last_erase = int'(addr);
              for (int i = 0; i < (1 << SECT_SHIFT); i++)
                mem[(int'(addr) & ~((1 << SECT_SHIFT) - 1)) + i] = 8'hFF;
              is_erase = 1; active = 1; nrd = 0;
            end else viol++;
            phase = 0;
          end
          default: phase = 0;
        endcase
      end
    end
    if (re) begin
      rd_cnt++;
      if (active && nrd < busy_reads) begin
        rdata <= {(is_erase ? 1'b0 : ~pend[7]), nrd[0], (nrd >= q5_at), 5'b0};
        nrd++;
      end else begin
        active = 0;
        rdata <= mem[addr];
      end
    end
  end

endmodule

// File: tb/flash_prog_ctrl_tb.sv
module flash_prog_ctrl_tb;

  localparam int AW = 12;
  localparam int CW = 4;
  localparam int SS = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          erase_op = 1'b0;
  logic          poll_toggle = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = 8'h00;
  logic          in_ready, busy, done, err;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata, fl_rdata;
  logic          fl_we, fl_re;

  always #5 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .CW(CW), .SECT_SHIFT(SS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .erase_op(erase_op),
    .poll_toggle(poll_toggle), .start_addr(start_addr), .byte_count(byte_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .busy(busy),
    .done(done), .err(err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  flash_model #(.AW(AW), .SECT_SHIFT(SS)) u_fm (
    .clk(clk), .addr(fl_addr), .wdata(fl_wdata), .we(fl_we), .re(fl_re), .rdata(fl_rdata)
  );

  int checks = 0;
  int fails  = 0;
  int r_dones, r_consumed, r_buswait;
  bit r_err, r_err_at_start;

  task automatic chk_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int i);
    return 8'((a * 29 + i * 83 + 17) ^ (i << 5));
  endfunction

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < (1 << AW); i++) u_fm.mem[i] = v;
  endtask

  task automatic run_op(input bit er, input bit tg, input int a, input int n,
                        input int b, input int q5, input int stall, input bit mid);
    int cyc = 0;
    int wl = stall;
    int post = 0;
    bit fin = 0;
    u_fm.busy_reads = b; u_fm.q5_at = q5;
    u_fm.rd_cnt = 0; u_fm.wr_cnt = 0; u_fm.rst_cnt = 0; u_fm.viol = 0;
    u_fm.last_erase = -1;
    r_dones = 0; r_consumed = 0; r_buswait = 0; r_err = 0;
    @(negedge clk);
    start = 1; erase_op = er; poll_toggle = tg;
    start_addr = AW'(a); byte_count = CW'(n);
    @(negedge clk);
    start = 0;
    r_err_at_start = err;
    while (!(fin && post >= 3) && cyc < 3000) begin
      if (done) begin
        r_dones++;
        if (!fin) r_err = err;
        fin = 1;
      end
      if (fin) post++;
      if (in_ready) begin
        if (wl > 0) begin
          in_valid = 0; wl--;
          if (fl_we || fl_re) r_buswait++;
        end else begin
          in_valid = 1; in_data = pat(a, r_consumed);
          r_consumed++; wl = stall;
        end
      end else in_valid = 0;
      if (mid && cyc == 6) begin
        start = 1; poll_toggle = !tg; erase_op = !er;
      end else start = 0;
      cyc++;
      @(negedge clk);
    end
    in_valid = 0; start = 0;
    if (cyc >= 3000) chk_eq("R10 run finished in time", 0, 1);
  endtask

  task automatic check_prog(input string tag, input int a, input int n, input int exp_rd);
    int bad = 0;
    chk_eq({tag, " R10 one done"}, r_dones, 1);
    chk_eq({tag, " R3 no error"}, int'(r_err), 0);
    chk_eq({tag, " R1 write count"}, u_fm.wr_cnt, 4 * n);
    chk_eq({tag, " R1 sequence order"}, u_fm.viol, 0);
    if (exp_rd >= 0) chk_eq({tag, " R5 read count"}, u_fm.rd_cnt, exp_rd);
    chk_eq({tag, " R7 bytes taken"}, r_consumed, n);
    chk_eq({tag, " R8 bus quiet in wait"}, r_buswait, 0);
    for (int i = 0; i < n; i++) if (u_fm.mem[a + i] != pat(a, i)) bad++;
    chk_eq({tag, " R7 programmed data"}, bad, 0);
    chk_eq({tag, " R7 next byte untouched"}, int'(u_fm.mem[a + n]), 255);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    fill(8'hFF);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 / R10 reset state
    chk_eq("R10 reset busy", int'(busy), 0);
    chk_eq("R10 reset done", int'(done), 0);
    chk_eq("R10 reset err", int'(err), 0);
    chk_eq("R8 reset ready", int'(in_ready), 0);
    chk_eq("R12 reset strobes", int'(fl_we) + int'(fl_re), 0);

    // Sweep: mode x count x busy length (R1 R3 R5 R7 R8)
    for (int m = 0; m < 2; m++)
      for (int n = 1; n <= 3; n++)
        for (int b = 0; b < 4; b++) begin
          int a = 100 + n * 40 + b * 7 + m * 300;
          int er;
          fill(8'hFF);
          run_op(1'b0, m[0], a, n, b, 1 << 30, b % 2, 1'b0);
          if (m == 0) er = n * (b + 1);
          else er = (b % 2 == 0) ? n * (b + 2) : -1;
          check_prog(m == 0 ? "sweep data-poll" : "sweep toggle", a, n, er);
        end

    // R2 erase, data-poll, unaligned address
    fill(8'h00);
    run_op(1'b1, 1'b0, 1500, 0, 3, 1 << 30, 0, 1'b0);
    begin
      int ff = 0;
      for (int i = 1024; i < 2048; i++) if (u_fm.mem[i] == 8'hFF) ff++;
      chk_eq("R2 sector erased", ff, 1024);
    end
    chk_eq("R2 erase at base", u_fm.last_erase, 1024);
    chk_eq("R2 six writes", u_fm.wr_cnt, 6);
    chk_eq("R2 sequence order", u_fm.viol, 0);
    chk_eq("R2 neighbours kept", int'(u_fm.mem[1023]) + int'(u_fm.mem[2048]), 0);
    chk_eq("R3 erase poll reads", u_fm.rd_cnt, 4);
    chk_eq("R3 erase no error", int'(r_err), 0);

    // R5 erase, toggle
    fill(8'h00);
    run_op(1'b1, 1'b1, 2100, 0, 2, 1 << 30, 0, 1'b0);
    chk_eq("R5 erase toggle base", u_fm.last_erase, 2048);
    chk_eq("R5 erase toggle reads", u_fm.rd_cnt, 4);
    chk_eq("R5 erase toggle ok", int'(r_err), 0);

    // R4 data-poll timeout -> failure
    fill(8'hFF);
    run_op(1'b0, 1'b0, 200, 3, 1000, 3, 0, 1'b0);
    chk_eq("R4 timeout error", int'(r_err), 1);
    chk_eq("R4 timeout reads", u_fm.rd_cnt, 5);
    chk_eq("R9 reset write", u_fm.rst_cnt, 1);
    chk_eq("R9 write count", u_fm.wr_cnt, 5);
    chk_eq("R9 no further bytes", r_consumed, 1);
    chk_eq("R9 later bytes untouched", int'(u_fm.mem[201]), 255);
    repeat (5) @(negedge clk);
    chk_eq("R10 err held", int'(err), 1);

    // R4 data-poll settles as timeout flag rises
    fill(8'hFF);
    run_op(1'b0, 1'b0, 600, 1, 4, 3, 0, 1'b0);
    chk_eq("R10 err cleared at start", int'(r_err_at_start), 0);
    check_prog("R4 settle", 600, 1, 5);

    // R6 toggle timeout -> failure
    fill(8'hFF);
    run_op(1'b0, 1'b1, 700, 2, 1000, 3, 0, 1'b0);
    chk_eq("R6 timeout error", int'(r_err), 1);
    chk_eq("R6 timeout reads", u_fm.rd_cnt, 6);
    chk_eq("R9 toggle reset write", u_fm.rst_cnt, 1);

    // R6 toggle settles as timeout flag rises
    fill(8'hFF);
    run_op(1'b0, 1'b1, 800, 1, 4, 3, 0, 1'b0);
    check_prog("R6 settle", 800, 1, 6);

    // R4 erase timeout on first read
    fill(8'h00);
    run_op(1'b1, 1'b0, 3000, 0, 1000, 0, 0, 1'b0);
    chk_eq("R4 erase fail error", int'(r_err), 1);
    chk_eq("R4 erase fail reads", u_fm.rd_cnt, 2);
    chk_eq("R9 erase fail writes", u_fm.wr_cnt, 7);

    // R7 zero count
    run_op(1'b0, 1'b0, 900, 0, 0, 1 << 30, 0, 1'b0);
    chk_eq("R7 zero count done", r_dones, 1);
    chk_eq("R7 zero count writes", u_fm.wr_cnt, 0);
    chk_eq("R7 zero count reads", u_fm.rd_cnt, 0);
    chk_eq("R7 zero count bytes", r_consumed, 0);

    // R10 / R11 start and mode change while busy
    fill(8'hFF);
    run_op(1'b0, 1'b0, 1000, 2, 1, 1 << 30, 0, 1'b1);
    chk_eq("R11 mode latched reads", u_fm.rd_cnt, 4);
    check_prog("R10 restart ignored", 1000, 2, 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule